// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block is the read path of a serial flash slave. It watches the chip-select, serial clock and serial input pins, takes in an 8-bit read command and a 24-bit address, MSB first, and skips the don't-care bytes that the command calls for. It then returns bytes MSB first on the serial output.

The bytes come from one of three sources: the main array, with 4096 pages of 528 bytes, or one of two 528-byte buffers. Each source has a synchronous read port with one cycle of latency. Each command has its own wrap rule:

- a continuous array read runs across pages and wraps from the end of the array to page 0;
- a page read stays inside one page;
- a buffer read stays inside its buffer.

The pins are sampled with a faster system clock, so the serial clock must run at one eighth of that clock or slower. Serial modes 0 and 3 both work. The block only ever acts on edges of the serial clock, so the level at which that clock idles does not matter.

The byte after the current one is fetched while the current byte is being shifted out. Raising chip-select ends the command and turns the output driver off. Write, erase and protection commands are not handled here.

Top module: `flash_read_seq`

## Requirements
- R1: After reset and while `cs_n` is high, `so_oe` is low and none of the three read enables is asserted from the next cycle on.
- R2: Command 0x03 takes three address bytes and no dummy byte. The first data bit appears after the falling SCK edge that follows the last address bit. Data comes out MSB first, and `so` changes only after a falling SCK edge.
- R3: Command 0x0B takes three address bytes and then one dummy byte before data.
- R4: Command 0xE8 takes three address bytes and then four dummy bytes before data.
- R5: In a continuous read (0x03, 0x0B, 0xE8), the byte after offset 527 is offset 0 of the next page, and each byte is fetched exactly once.
- R6: In a continuous read, the byte after page 4095 offset 527 is page 0 offset 0.
- R7: Command 0xD2 takes four dummy bytes and reads one page. After offset 527 it returns to offset 0 of the same page.
- R8: Commands 0xD4 and 0xD1 read buffer 1, and 0xD6 and 0xD3 read buffer 2. Each takes one dummy byte after the address. The buffer address is the low 10 address bits, and after byte 527 the read returns to byte 0.
- R9: Array commands never assert a buffer read enable, and buffer commands never assert the array read enable.
- R10: Any other command byte is ignored until `cs_n` rises: `so_oe` stays low and no read enable is asserted.
- R11: Raising `cs_n` in the middle of a data stream ends it, and the next command starts cleanly.
- R12: Address bits 21..10 give the page and bits 9..0 give the byte offset. Bits 23..22 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, taken on the rising SCK edge |
| so | output | 1 | Serial data out, changed after the falling SCK edge |
| so_oe | output | 1 | Output enable for `so` |
| arr_rd_en | output | 1 | Array read strobe |
| arr_page | output | 12 | Array page number |
| arr_col | output | 10 | Byte offset within the page |
| arr_rdata | input | 8 | Array read data, valid one cycle after the strobe |
| buf1_rd_en | output | 1 | Buffer 1 read strobe |
| buf2_rd_en | output | 1 | Buffer 2 read strobe |
| buf_addr | output | 10 | Buffer byte address |
| buf1_rdata | input | 8 | Buffer 1 read data, valid one cycle after the strobe |
| buf2_rdata | input | 8 | Buffer 2 read data, valid one cycle after the strobe |

## Verification
Each command is run with a start address chosen so that its stream crosses the boundary its wrap rule governs:

- a page end for the continuous and page reads;
- the end of the array for a continuous read;
- the end of a buffer for the buffer reads.

A wrong rule therefore shows up as a wrong byte. Each of the three dummy counts is tried. Getting a count wrong by one byte shifts the whole stream, so each count is told apart from the others.

The same traffic is also sent in mode 3, with bits 23..22 of the address set, to show that the idle level of SCK and the top address bits have no effect. An unknown command, and a read cut short by a chip-select rise, show that stray traffic neither drives the output nor starts a fetch.

// File: rtl/flash_read_seq.sv
module flash_read_seq #(
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_W     = 12,
  parameter int COL_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              arr_rd_en,
  output logic [PAGE_W-1:0] arr_page,
  output logic [COL_W-1:0]  arr_col,
  input  logic [7:0]        arr_rdata,
  output logic              buf1_rd_en,
  output logic              buf2_rd_en,
  output logic [COL_W-1:0]  buf_addr,
  input  logic [7:0]        buf1_rdata,
  input  logic [7:0]        buf2_rdata
);
  localparam int AH_W = PAGE_W + COL_W - 8;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_DATA, S_SKIP} phase_t;
  typedef enum logic [1:0] {M_CONT, M_PAGE, M_BUF1, M_BUF2} mode_t;

  phase_t            phase;
  mode_t             mode, dec_mode;
  logic              sck_q, req, got, live, dec_ok;
  logic [2:0]        bitc, obit, cnt, nd, dec_nd;
  logic [6:0]        sin;
  logic [AH_W-1:0]   a_hold;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [7:0]        pre, sreg;

  wire       rise      = ~cs_n & sck & ~sck_q;
  wire       fall      = ~cs_n & ~sck & sck_q;
  wire [7:0] byte_in   = {sin, si};
  wire       byte_done = rise && bitc == 3'd7;
  wire       wrap      = col >= LAST_COL;
  wire [COL_W-1:0]  col_nx  = wrap ? '0 : col + 1'b1;
  wire [PAGE_W-1:0] page_nx = (mode == M_CONT && wrap) ? page + 1'b1 : page;

  always_comb begin
    dec_ok   = 1'b1;
    dec_mode = M_CONT;
    dec_nd   = 3'd0;
    case (byte_in)
      8'h03: dec_nd = 3'd0;
      8'h0B: dec_nd = 3'd1;
      8'hE8: dec_nd = 3'd4;
      8'hD2: begin dec_mode = M_PAGE; dec_nd = 3'd4; end
      8'hD4, 8'hD1: begin dec_mode = M_BUF1; dec_nd = 3'd1; end
      8'hD6, 8'hD3: begin dec_mode = M_BUF2; dec_nd = 3'd1; end
      default: dec_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_CMD; mode <= M_CONT; sck_q <= 1'b0;
      req <= 1'b0; got <= 1'b0; live <= 1'b0;
      bitc <= '0; obit <= '0; cnt <= '0; nd <= '0;
      sin <= '0; a_hold <= '0; page <= '0; col <= '0;
      pre <= '0; sreg <= '0;
    end else begin
      sck_q <= sck;
      got   <= req;
      req   <= 1'b0;
      if (got)
        case (mode)
          M_BUF1:  pre <= buf1_rdata;
          M_BUF2:  pre <= buf2_rdata;
          default: pre <= arr_rdata;
        endcase
      if (cs_n) begin
        phase <= S_CMD; bitc <= '0; obit <= '0; cnt <= '0;
        live <= 1'b0; got <= 1'b0;
      end else begin
        if (rise) begin
          sin  <= byte_in[6:0];
          bitc <= bitc + 1'b1;
        end
        if (byte_done)
          case (phase)
            S_CMD:
              if (dec_ok) begin
                mode <= dec_mode; nd <= dec_nd; cnt <= '0; phase <= S_ADDR;
              end else phase <= S_SKIP;
            S_ADDR: begin
              a_hold <= AH_W'({a_hold, byte_in});
              cnt    <= cnt + 1'b1;
              if (cnt == 3'd2) begin
                page <= a_hold[AH_W-1:COL_W-8];
                col  <= {a_hold[COL_W-9:0], byte_in};
                cnt  <= '0;
                if (nd == 3'd0) begin phase <= S_DATA; req <= 1'b1; end
                else phase <= S_DUMMY;
              end
            end
            S_DUMMY: begin
              cnt <= cnt + 1'b1;
              if (cnt == nd - 1'b1) begin phase <= S_DATA; req <= 1'b1; end
            end
            default: ;
          endcase
        if (phase == S_DATA && fall) begin
          live <= 1'b1;
          obit <= obit + 1'b1;
          if (obit == 3'd0) begin
            sreg <= pre;
            col  <= col_nx;
            page <= page_nx;
            req  <= 1'b1;
          end else sreg <= {sreg[6:0], 1'b0};
        end
      end
    end
  end

  assign so         = live & sreg[7];
  assign so_oe      = live & ~cs_n;
  assign arr_rd_en  = req & (mode == M_CONT || mode == M_PAGE);
  assign buf1_rd_en = req & (mode == M_BUF1);
  assign buf2_rd_en = req & (mode == M_BUF2);
  assign arr_page   = page;
  assign arr_col    = col;
  assign buf_addr   = col;
endmodule

// File: rtl/flash_read_seq_chk.sv
module flash_read_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic so,
  input logic so_oe,
  input logic arr_rd_en,
  input logic buf1_rd_en,
  input logic buf2_rd_en
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !so_oe && !arr_rd_en && !buf1_rd_en && !buf2_rd_en); // R1

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe && $past(so_oe) && !(!$past(sck) && $past(sck, 2))) |-> $stable(so)); // R2

  AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_rd_en, buf1_rd_en, buf2_rd_en})); // R9

  AST_ONE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> !arr_rd_en); // R5
endmodule

bind flash_read_seq flash_read_seq_chk chk_i (.*);

// File: tb/flash_read_seq_tb_top.sv
module flash_read_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, arr_rd_en, buf1_rd_en, buf2_rd_en;
  logic [11:0] arr_page;
  logic [9:0]  arr_col, buf_addr;
  logic [7:0]  arr_rdata = '0, buf1_rdata = '0, buf2_rdata = '0;
  int checks = 0, errors = 0, n_arr = 0, n_b1 = 0, n_b2 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_read_seq dut_i (.*);

  function automatic logic [7:0] arr_f(input int p, input int c);
    return 8'(p * 13 + c * 7 + (c >> 8) * 3);
  endfunction
  function automatic logic [7:0] b1_f(input int c);
    return 8'(c * 5 + 1 + (c >> 8));
  endfunction
  function automatic logic [7:0] b2_f(input int c);
    return ~8'(c * 3 + (c >> 8) * 11);
  endfunction

  always @(posedge clk) begin
    if (arr_rd_en) begin arr_rdata <= arr_f(arr_page, arr_col); n_arr++; end
    if (buf1_rd_en) begin buf1_rdata <= b1_f(buf_addr); n_b1++; end
    if (buf2_rd_en) begin buf2_rdata <= b2_f(buf_addr); n_b2++; end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xbit(input logic v, output logic o, output logic oe);
    @(negedge clk); sck = 1'b0; si = v;
    repeat (3) @(negedge clk);
    o = so; oe = so_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] o, output logic oe_all, output logic oe_any);
    logic ob, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xbit(b[i], ob, oe);
      o[i] = ob; oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic begin_cmd(input logic m3);
    @(negedge clk); sck = m3; n_arr = 0; n_b1 = 0; n_b2 = 0;
    repeat (2) @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_cmd(input logic m3, input string rq);
    @(negedge clk); sck = m3;
    repeat (2) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!so_oe && !arr_rd_en && !buf1_rd_en && !buf2_rd_en, rq, so_oe, 0);
  endtask

  // kind: 0 continuous, 1 page, 2 buffer 1, 3 buffer 2
  task automatic run_read(input logic m3, input logic [7:0] op, input logic [23:0] addr,
                          input int ndum, input int nbytes, input int kind, input string rq);
    logic [7:0] o, exp;
    logic oa, on;
    int p, c;
    p = int'(addr[21:10]); c = int'(addr[9:0]);
    begin_cmd(m3);
    xbyte(op, o, oa, on);
    for (int i = 2; i >= 0; i--) begin
      xbyte(addr[i*8 +: 8], o, oa, on);
      chk(!on, rq, on, 0);
    end
    for (int i = 0; i < ndum; i++) begin
      xbyte(8'hA5, o, oa, on);
      chk(!on, rq, on, 0);
    end
    for (int i = 0; i < nbytes; i++) begin
      xbyte(8'h00, o, oa, on);
      exp = (kind == 0 || kind == 1) ? arr_f(p, c) : (kind == 2) ? b1_f(c) : b2_f(c);
      chk(o == exp && oa, rq, o, exp);
      if (c >= 527) begin c = 0; if (kind == 0) p = (p + 1) % 4096; end
      else c++;
    end
    end_cmd(m3, rq);
    if (kind < 2) chk(n_b1 == 0 && n_b2 == 0, "R9", n_b1 + n_b2, 0);
    else chk(n_arr == 0 && ((kind == 2) ? n_b2 == 0 : n_b1 == 0), "R9", n_arr, 0);
  endtask

  task automatic t_reset;
    chk(!so_oe && !arr_rd_en && !buf1_rd_en && !buf2_rd_en, "R1", so_oe, 0);
  endtask

  task automatic t_plain;      // R2, R12 (top address bits set)
    run_read(1'b0, 8'h03, {2'b11, 12'h123, 10'h045}, 0, 4, 0, "R2");
    run_read(1'b1, 8'h03, {2'b10, 12'h0A0, 10'h200}, 0, 3, 0, "R12");
  endtask

  task automatic t_dummies;    // R3, R4, R5, R6
    run_read(1'b0, 8'h0B, {2'b00, 12'h010, 10'd3}, 1, 3, 0, "R3");
    run_read(1'b0, 8'hE8, {2'b00, 12'd7, 10'd526}, 4, 4, 0, "R5");
    run_read(1'b1, 8'h0B, {2'b00, 12'd4095, 10'd526}, 1, 4, 0, "R6");
    run_read(1'b0, 8'hE8, {2'b00, 12'h3FF, 10'h0FF}, 4, 2, 0, "R4");
  endtask

  task automatic t_page;       // R7
    run_read(1'b0, 8'hD2, {2'b00, 12'd5, 10'd526}, 4, 4, 1, "R7");
  endtask

  task automatic t_buffers;    // R8, R9
    run_read(1'b0, 8'hD4, {14'h3FFF, 10'd526}, 1, 4, 2, "R8");
    run_read(1'b1, 8'hD1, {14'h0, 10'd300}, 1, 2, 2, "R8");
    run_read(1'b0, 8'hD6, {14'h0, 10'd527}, 1, 3, 3, "R8");
    run_read(1'b1, 8'hD3, {14'h1, 10'd17}, 1, 2, 3, "R8");
  endtask

  task automatic t_unknown;    // R10
    logic [7:0] o;
    logic oa, on, any;
    any = 1'b0;
    begin_cmd(1'b0);
    xbyte(8'h9F, o, oa, on); any |= on;
    for (int i = 0; i < 6; i++) begin xbyte(8'hFF, o, oa, on); any |= on; end
    chk(!any, "R10", any, 0);
    chk(n_arr == 0 && n_b1 == 0 && n_b2 == 0, "R10", n_arr + n_b1 + n_b2, 0);
    end_cmd(1'b0, "R10");
  endtask

  task automatic t_abort;      // R11
    run_read(1'b0, 8'h03, {2'b00, 12'd2, 10'd10}, 0, 1, 0, "R11");
    run_read(1'b0, 8'hD4, {14'h0, 10'd40}, 1, 2, 2, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_dummies();
    t_page();
    t_buffers();
    t_unknown();
    t_abort();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule